// File: doc/BRIEF.md
# Filtered Performance Event Counter

This block is one hardware performance counter for a processor core. Each cycle it looks at a wide vector of event conditions, organised as 32 groups of 16 conditions. It picks one group through a select field and keeps only the conditions chosen by a 16-bit mask. If any kept condition is true, and the current interrupt level passes a programmable privilege filter, the 32-bit count advances by exactly one.

Software configures the counter through a small register port. That port also lets software preload or read the count, inspect and clear the status bits, and read back a captured program counter. A global enable gates all counting.

When the count wraps from all ones to zero, a sticky overflow flag is set. If interrupts are enabled, the wrap also latches an interrupt-source flag, which drives the interrupt output. It records the PC of the cycle whose event caused the wrap, so a profiler can attribute the sample.

Top module: `evt_perf_counter`

## Requirements
- R1: After reset, every readable register (addresses 0 to 4) reads 0 and `irq_o` is low; unused addresses read 0.
- R2: Bit 0 of the global control register (address 0) must be 1 for any count to happen; while it is 0, the count holds its value whatever the events do.
- R3: The configuration register (address 1) holds the mask in bits [15:0] and the group select in bits [20:16]. Group g occupies bits [g*16+15 : g*16] of `evt_bus_i`. A cycle qualifies only if some bit of the selected group is 1 where the mask bit is also 1.
- R4: However many masked conditions are true in one cycle, the count advances by exactly one, on the clock edge that ends that cycle.
- R5: With configuration bit 25 (above mode) set, counting happens only when `int_level_i` is strictly greater than the threshold in bits [24:21].
- R6: With configuration bit 25 clear, counting happens only when `int_level_i` is less than or equal to the threshold.
- R7: An increment from 0xFFFFFFFF yields 0 and sets status bit 0 (overflow). That bit stays set through later counts until it is cleared.
- R8: If configuration bit 26 (interrupt enable) is set at a wrap, status bit 1 (interrupt source) is set and `irq_o` goes high on the next cycle. With bit 26 clear, a wrap leaves bit 1 and `irq_o` at 0.
- R9: The PC register (address 4) captures `pc_i` from the cycle whose event caused an interrupt-raising wrap, but only while status bit 1 was 0. A later wrap does not overwrite it while the source bit is still set.
- R10: Writing the status register (address 3) clears each status bit written as 1. Clearing bit 1 drops `irq_o`. A wrap in the same cycle wins over the clear.
- R11: A write to the count register (address 2) loads the written value, and that write takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_bus_i | input | 512 | Event conditions, 32 groups of 16 |
| int_level_i | input | 4 | Current interrupt level of the core |
| pc_i | input | 32 | PC of the current cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| irq_o | output | 1 | Performance-monitor interrupt |

## Verification
A wrong select decode, mask or level comparison shows up as a count that is off by one when read back one cycle after the event. A counter that adds more than one per cycle shows up the same way. A mis-set or non-sticky status bit is visible on the status read and on `irq_o` in the cycle after the wrap. A wrong PC capture policy appears only after a second interrupt-raising wrap, so the bench forces one.

// File: rtl/evtcnt_pkg.sv
// Shared types for the filtered event counter.
// Assumes a 32-bit register port; field layout of the configuration word is fixed here.
package evtcnt_pkg;
    localparam int GRP_W = 16;
    localparam int SEL_W = 5;
    localparam int LVL_W = 4;
    localparam int CFG_W = 1 + 1 + LVL_W + SEL_W + GRP_W;

    typedef enum logic [2:0] {
        ADR_GCTL  = 3'd0,
        ADR_CFG   = 3'd1,
        ADR_COUNT = 3'd2,
        ADR_STAT  = 3'd3,
        ADR_PC    = 3'd4
    } reg_addr_e;

    // Packed MSB first: irq_en at bit 26, mask at bits [15:0].
    typedef struct packed {
        logic             irq_en;
        logic             above;
        logic [LVL_W-1:0] thr;
        logic [SEL_W-1:0] sel;
        logic [GRP_W-1:0] mask;
    } cfg_t;
endpackage

// File: rtl/evtcnt_filter.sv
// Event qualification: picks one group of the event bus, masks it, ORs it,
// and gates the result with the global enable and the interrupt-level filter.
// Assumes the bus holds 2**SEL_W groups of GRP_W bits, group g at [g*GRP_W +: GRP_W].
module evtcnt_filter #(
    parameter int GRP_W = 16,
    parameter int SEL_W = 5,
    parameter int LVL_W = 4,
    localparam int NGRP = 1 << SEL_W
) (
    input  logic [NGRP*GRP_W-1:0] evt_bus,
    input  logic [SEL_W-1:0]      sel,
    input  logic [GRP_W-1:0]      mask,
    input  logic                  above,
    input  logic [LVL_W-1:0]      thr,
    input  logic [LVL_W-1:0]      lvl,
    input  logic                  enable,
    output logic                  hit
);
    logic [GRP_W-1:0] grp_arr [NGRP];
    logic [GRP_W-1:0] grp_sel;
    logic             any_cond;
    logic             lvl_ok;

    // Slice the flat bus into groups.
    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        assign grp_arr[g] = evt_bus[g*GRP_W +: GRP_W];
    end

    // Choose group, mask it and reduce to one condition per cycle.
    always_comb begin
        grp_sel  = grp_arr[sel];
        any_cond = |(grp_sel & mask);
    end

    // Privilege filter: above mode needs level > threshold, else level <= threshold.
    always_comb begin
        lvl_ok = above ? (lvl > thr) : (lvl <= thr);
        hit    = enable & any_cond & lvl_ok;
    end
endmodule

// File: rtl/evtcnt_core.sv
// Count register with software load. A load wins over an increment.
// Emits a one-cycle wrap pulse when an increment leaves the all-ones value.
module evtcnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    // Wrap happens only on a real increment from all ones.
    always_comb wrap = inc & ~wr_en & (&count);

    // Count update: load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (wr_en) count <= wr_data;
        else if (inc)   count <= count + 1'b1;
    end

    assert_load_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));
    assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en) |=> count == CNT_W'($past(count) + 1'b1));
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !wr_en) |=> $stable(count));
endmodule

// File: rtl/evtcnt_status.sv
// Sticky status: overflow flag, interrupt-source flag and captured PC.
// Assumes wrap is a one-cycle pulse; a set in the same cycle as a clear wins.
module evtcnt_status #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap,
    input  logic            irq_en,
    input  logic [PC_W-1:0] pc,
    input  logic            clr_we,
    input  logic [1:0]      clr_bits,
    output logic            ovf,
    output logic            src,
    output logic [PC_W-1:0] pc_cap
);
    logic raise;

    // An interrupt is raised by a wrap with interrupts enabled.
    always_comb raise = wrap & irq_en;

    // Sticky overflow bit, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf <= 1'b0;
        else        ovf <= wrap | (ovf & ~(clr_we & clr_bits[0]));
    end

    // Sticky interrupt-source bit, write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) src <= 1'b0;
        else        src <= raise | (src & ~(clr_we & clr_bits[1]));
    end

    // Capture PC of the first raising wrap while no interrupt is pending.
    always_ff @(posedge clk) begin
        if (!rst_n)              pc_cap <= '0;
        else if (raise && !src)  pc_cap <= pc;
    end

    assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf);
    assert_raise_sets_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        raise |=> src);
    assert_src_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(src) |-> $past(wrap && irq_en));
    assert_pc_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        src |=> $stable(pc_cap));
endmodule

// File: rtl/evt_perf_counter.sv
// Top of the filtered performance counter: register port, configuration
// storage and read mux around the filter, count and status sub-blocks.
// Assumes single-cycle register writes and a combinational read path.
module evt_perf_counter #(
    parameter int CNT_W = 32,
    parameter int PC_W  = 32,
    localparam int NGRP  = 1 << evtcnt_pkg::SEL_W,
    localparam int BUS_W = NGRP * evtcnt_pkg::GRP_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [BUS_W-1:0]             evt_bus_i,
    input  logic [evtcnt_pkg::LVL_W-1:0] int_level_i,
    input  logic [PC_W-1:0]              pc_i,
    input  logic                         reg_we_i,
    input  logic [2:0]                   reg_addr_i,
    input  logic [31:0]                  reg_wdata_i,
    output logic [31:0]                  reg_rdata_o,
    output logic                         irq_o
);
    import evtcnt_pkg::*;

    logic             gbl_en;
    cfg_t             cfg_q;
    logic             hit;
    logic             cnt_we;
    logic             stat_we;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             ovf;
    logic             src;
    logic [PC_W-1:0]  pc_cap;

    // Decode register writes.
    always_comb begin
        cnt_we  = reg_we_i && (reg_addr_i == ADR_COUNT);
        stat_we = reg_we_i && (reg_addr_i == ADR_STAT);
    end

    // Global enable and configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gbl_en <= 1'b0;
            cfg_q  <= '0;
        end else if (reg_we_i) begin
            if (reg_addr_i == ADR_GCTL) gbl_en <= reg_wdata_i[0];
            if (reg_addr_i == ADR_CFG)  cfg_q  <= cfg_t'(reg_wdata_i[CFG_W-1:0]);
        end
    end

    evtcnt_filter #(.GRP_W(GRP_W), .SEL_W(SEL_W), .LVL_W(LVL_W)) u_filter (
        .evt_bus (evt_bus_i),
        .sel     (cfg_q.sel),
        .mask    (cfg_q.mask),
        .above   (cfg_q.above),
        .thr     (cfg_q.thr),
        .lvl     (int_level_i),
        .enable  (gbl_en),
        .hit     (hit)
    );

    evtcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (hit),
        .wr_en   (cnt_we),
        .wr_data (reg_wdata_i[CNT_W-1:0]),
        .count   (count),
        .wrap    (wrap)
    );

    evtcnt_status #(.PC_W(PC_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .irq_en   (cfg_q.irq_en),
        .pc       (pc_i),
        .clr_we   (stat_we),
        .clr_bits (reg_wdata_i[1:0]),
        .ovf      (ovf),
        .src      (src),
        .pc_cap   (pc_cap)
    );

    // Interrupt follows the source flag.
    always_comb irq_o = src;

    // Read mux, zero for unused addresses.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADR_GCTL:  reg_rdata_o[0]         = gbl_en;
            ADR_CFG:   reg_rdata_o[CFG_W-1:0] = cfg_q;
            ADR_COUNT: reg_rdata_o[CNT_W-1:0] = count;
            ADR_STAT:  reg_rdata_o[1:0]       = {src, ovf};
            ADR_PC:    reg_rdata_o[PC_W-1:0]  = pc_cap;
            default:   reg_rdata_o            = '0;
        endcase
    end

    assert_disabled_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!gbl_en && !cnt_we) |=> $stable(count));
    assert_irq_off_no_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.irq_en && !src) |=> !irq_o);
endmodule

// File: tb/evt_perf_counter_tb.sv
module evt_perf_counter_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [511:0] evt_bus_i = '0;
    logic [3:0]   int_level_i = '0;
    logic [31:0]  pc_i = '0;
    logic         reg_we_i = 1'b0;
    logic [2:0]   reg_addr_i = '0;
    logic [31:0]  reg_wdata_i = '0;
    logic [31:0]  reg_rdata_o;
    logic         irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    evt_perf_counter dut_i (
        .clk(clk), .rst_n(rst_n), .evt_bus_i(evt_bus_i), .int_level_i(int_level_i),
        .pc_i(pc_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic [4:0]  sel;
        logic [4:0]  grp;
        logic [15:0] mask;
        logic        above;
        logic [3:0]  thr;
        logic [3:0]  lvl;
        logic [15:0] val;
        logic        inc;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{5'd0,  5'd0,  16'hFFFF, 1'b0, 4'd0,  4'd0,  16'h0001, 1'b1}, // R6 level == thr
        '{5'd3,  5'd3,  16'h00F0, 1'b0, 4'd5,  4'd5,  16'h0030, 1'b1}, // R4 two bits, one count
        '{5'd3,  5'd3,  16'h00F0, 1'b0, 4'd5,  4'd6,  16'h0030, 1'b0}, // R6 level above
        '{5'd7,  5'd7,  16'h0F00, 1'b1, 4'd5,  4'd6,  16'h0100, 1'b1}, // R5 level > thr
        '{5'd7,  5'd7,  16'h0F00, 1'b1, 4'd5,  4'd5,  16'h0100, 1'b0}, // R5 level == thr
        '{5'd31, 5'd31, 16'h8000, 1'b1, 4'd14, 4'd15, 16'h8000, 1'b1}, // R3 top group, top bit
        '{5'd10, 5'd10, 16'h00FF, 1'b0, 4'd15, 4'd9,  16'hFF00, 1'b0}, // R3 masked out
        '{5'd10, 5'd10, 16'hFFFF, 1'b0, 4'd15, 4'd9,  16'hFFFF, 1'b1}, // R4 sixteen bits
        '{5'd2,  5'd3,  16'hFFFF, 1'b0, 4'd15, 4'd0,  16'hFFFF, 1'b0}, // R3 other group
        '{5'd0,  5'd0,  16'h0000, 1'b0, 4'd15, 4'd0,  16'hFFFF, 1'b0}  // R3 empty mask
    };

    function automatic logic [31:0] mk_cfg(logic irq, logic above, logic [3:0] thr,
                                           logic [4:0] sel, logic [15:0] mask);
        return {5'b0, irq, above, thr, sel, mask};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic pulse_evt(logic [4:0] g, logic [15:0] v, logic [3:0] lvl, logic [31:0] pc);
        @(negedge clk);
        evt_bus_i = '0;
        evt_bus_i[g*16 +: 16] = v;
        int_level_i = lvl;
        pc_i = pc;
        @(negedge clk);
        evt_bus_i = '0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], r);
            check("R1 reset read", r, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // R2 global enable off: no count
        wr(3'd1, mk_cfg(1'b0, 1'b0, 4'd15, 5'd0, 16'hFFFF));
        wr(3'd2, 32'd40);
        pulse_evt(5'd0, 16'hFFFF, 4'd0, 32'h0);
        rd(3'd2, r);
        check("R2 disabled holds", r, 32'd40);

        wr(3'd0, 32'h1);
        // Vector table: R3..R6
        foreach (VECS[i]) begin
            wr(3'd1, mk_cfg(1'b0, VECS[i].above, VECS[i].thr, VECS[i].sel, VECS[i].mask));
            wr(3'd2, 32'd100);
            pulse_evt(VECS[i].grp, VECS[i].val, VECS[i].lvl, 32'h0);
            rd(3'd2, r);
            check($sformatf("R3-vec%0d R4 R5 R6 count", i), r, 32'd100 + {31'b0, VECS[i].inc});
        end

        // R11 write beats increment in the same cycle
        wr(3'd1, mk_cfg(1'b0, 1'b0, 4'd15, 5'd0, 16'hFFFF));
        wr(3'd2, 32'd50);
        @(negedge clk);
        evt_bus_i[15:0] = 16'hFFFF; int_level_i = 4'd0;
        reg_we_i = 1'b1; reg_addr_i = 3'd2; reg_wdata_i = 32'd7;
        @(negedge clk);
        reg_we_i = 1'b0; evt_bus_i = '0;
        rd(3'd2, r);
        check("R11 write priority", r, 32'd7);

        // R7 wrap with interrupts off, R8 no interrupt
        wr(3'd2, 32'hFFFF_FFFF);
        pulse_evt(5'd0, 16'h0001, 4'd0, 32'hDEAD_0001);
        rd(3'd2, r);
        check("R7 wrap to zero", r, 32'h0);
        rd(3'd3, r);
        check("R7 R8 status ovf only", r, 32'h1);
        check("R8 irq stays low", {31'b0, irq_o}, 32'h0);
        rd(3'd4, r);
        check("R9 no capture without irq", r, 32'h0);
        pulse_evt(5'd0, 16'h0001, 4'd0, 32'h0);
        rd(3'd3, r);
        check("R7 sticky", r, 32'h1);
        wr(3'd3, 32'h1);
        rd(3'd3, r);
        check("R10 clear ovf", r, 32'h0);

        // R8 R9 wrap with interrupts on
        wr(3'd1, mk_cfg(1'b1, 1'b0, 4'd15, 5'd0, 16'hFFFF));
        wr(3'd2, 32'hFFFF_FFFF);
        pulse_evt(5'd0, 16'h0002, 4'd3, 32'h1234_5678);
        rd(3'd3, r);
        check("R8 status both", r, 32'h3);
        check("R8 irq high", {31'b0, irq_o}, 32'h1);
        rd(3'd4, r);
        check("R9 pc captured", r, 32'h1234_5678);
        wr(3'd2, 32'hFFFF_FFFF);
        pulse_evt(5'd0, 16'h0002, 4'd3, 32'hAAAA_0000);
        rd(3'd4, r);
        check("R9 pc held while pending", r, 32'h1234_5678);

        // R10 clear source only, then overflow
        wr(3'd3, 32'h2);
        rd(3'd3, r);
        check("R10 clear src", r, 32'h1);
        check("R10 irq drops", {31'b0, irq_o}, 32'h0);
        wr(3'd3, 32'h1);
        rd(3'd3, r);
        check("R10 clear ovf", r, 32'h0);

        // R9 a new capture after the clear
        wr(3'd2, 32'hFFFF_FFFF);
        pulse_evt(5'd0, 16'h0002, 4'd3, 32'h0BAD_F00D);
        rd(3'd4, r);
        check("R9 recapture after clear", r, 32'h0BAD_F00D);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule